// File: doc/BRIEF.md
# One-Bit Cell Array with Torus or Chain Edge Links

A rectangular grid of ROWS x COLS identical one-bit cells that all obey one broadcast instruction on every clock edge. Each cell has a private 1-bit-wide RAM, a vertical register, a horizontal register, a carry register, a one-bit adder/subtractor and a bypass register. The instruction word is split into five fields. Each field picks the next value of one register, or the source that the RAM writes. All five fields act in the same cycle.

The bypass registers form a separate south-to-north shift path. Words enter on `south_in`, march one row per cycle and leave on `north_out`. This path works independently of the compute registers, so a data stream can move through the array while the cells compute.

A registered mode bit sets how the edges of the grid are wired. In torus mode, every edge wraps to the opposite edge, which gives a cyclic 2D lattice. In chain mode, the horizontal links form one serpentine line, which gives an acyclic 1D automaton.

Top module: `simd_cell_array`

## Requirements
- R1: While `rst_n` is low, every register, every RAM bit and the mode bit are cleared. The mode bit cleared means torus mode, and `north_out` reads 0.
- R2: Bypass field `instr[1:0]` selects the next bypass register value: 00 holds, 01 loads the RAM bit at `addr`, 10 takes the bypass register of the cell one row south (the bottom row takes `south_in[c]`), 11 clears. `north_out[c]` is the bypass register of row 0, column c.
- R3: A word driven on `south_in` while field 10 is applied every cycle appears unchanged on `north_out` exactly ROWS cycles later.
- R4: Vertical field `instr[4:2]` selects: 000 hold, 001 RAM, 010 the vertical register of the north neighbour, 011 that of the south neighbour, 100 the own horizontal register, 101 the own carry register, 110 zero, 111 hold.
- R5: Horizontal field `instr[7:5]` selects: 000 hold, 001 RAM, 010 the horizontal register of the east neighbour, 011 that of the west neighbour, 100 the own vertical register, 101 the own carry register, 110 zero, 111 hold.
- R6: Carry field `instr[10:8]` selects: 000 hold, 001 RAM, 010 vertical, 011 horizontal, 100 the carry out of vertical+horizontal+carry, 101 the borrow out of vertical-horizontal-carry, 110 zero, 111 one.
- R7: When `wr_en` is 1, the RAM bit at `addr` is written on the edge from the source in `instr[12:11]`: 00 its own old value, 01 bypass, 10 carry, 11 the sum bit of the adder. When `wr_en` is 0, no RAM bit changes. A register that reads RAM in the same cycle sees the old value.
- R8: In torus mode, the north edge wraps to the south edge (always), and column 0 and column COLS-1 of the same row are west/east neighbours.
- R9: In chain mode, the west input of column 0 in row r is the horizontal register of row r+1, column COLS-1, and the east input of row r, column COLS-1 is row r-1, column 0. The west input of the bottom row and the east input of the top row read 0. The vertical links keep wrapping.
- R10: The mode bit takes `chain_mode` (1 = chain) only on an edge where `instr` is all zero. On any other edge it keeps its value.
- R11: A bypass shift and operations on the compute registers and RAM given in the same instruction all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 13 | Broadcast instruction word |
| addr | input | ADDR_W | Broadcast RAM bit address |
| wr_en | input | 1 | RAM write enable (1 write, 0 read only) |
| chain_mode | input | 1 | Edge wiring request, 1 = chain, 0 = torus |
| south_in | input | COLS | Word entering the bypass path at the bottom row |
| north_out | output | COLS | Bypass registers of the top row |

## Verification
The hardest situation to reach is the chain-mode seam: the one-cycle transfer between the end of one row and the start of the row above, plus the zero fed in at the two open ends. The only port that shows cell state is the top row of the bypass path, so the stimulus works in four stages. It loads the horizontal registers from RAM, shifts them one step, moves them through the carry register back into RAM, and then reads RAM out row by row through the bypass path. The same route checks a torus rotation and the hold of the mode bit while non-zero instructions carry a changed mode request. A reference model runs alongside through a long randomized stretch and compares `north_out` on every cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int INSTR_W = 13;

    typedef enum logic [1:0] {
        BY_HOLD  = 2'b00,
        BY_RAM   = 2'b01,
        BY_SOUTH = 2'b10,
        BY_ZERO  = 2'b11
    } byp_op_e;

    typedef enum logic [2:0] {
        V_HOLD  = 3'b000,
        V_RAM   = 3'b001,
        V_NORTH = 3'b010,
        V_SOUTH = 3'b011,
        V_HORZ  = 3'b100,
        V_CARRY = 3'b101,
        V_ZERO  = 3'b110,
        V_KEEP  = 3'b111
    } vert_op_e;

    typedef enum logic [2:0] {
        H_HOLD  = 3'b000,
        H_RAM   = 3'b001,
        H_EAST  = 3'b010,
        H_WEST  = 3'b011,
        H_VERT  = 3'b100,
        H_CARRY = 3'b101,
        H_ZERO  = 3'b110,
        H_KEEP  = 3'b111
    } horz_op_e;

    typedef enum logic [2:0] {
        C_HOLD  = 3'b000,
        C_RAM   = 3'b001,
        C_VERT  = 3'b010,
        C_HORZ  = 3'b011,
        C_CY    = 3'b100,
        C_BW    = 3'b101,
        C_ZERO  = 3'b110,
        C_ONE   = 3'b111
    } carry_op_e;

    typedef enum logic [1:0] {
        W_RAM   = 2'b00,
        W_BYP   = 2'b01,
        W_CARRY = 2'b10,
        W_SUM   = 2'b11
    } wsrc_e;

    typedef struct packed {
        wsrc_e     wsrc;
        carry_op_e carry;
        horz_op_e  horz;
        vert_op_e  vert;
        byp_op_e   byp;
    } instr_t;

endpackage

// File: rtl/simd_cell.sv
module simd_cell
    import simd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  instr_t            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              n_in,
    input  logic              s_in,
    input  logic              e_in,
    input  logic              w_in,
    input  logic              byp_in,
    output logic              vr_o,
    output logic              hr_o,
    output logic              byp_o
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic             vr;
        logic             hr;
        logic             cr;
        logic             bp;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic rd_bit, sum_bit, cy_bit, bw_bit;

    always_comb begin
        st_d    = st_q;
        rd_bit  = st_q.mem[addr];
        sum_bit = st_q.vr ^ st_q.hr ^ st_q.cr;
        cy_bit  = (st_q.vr & st_q.hr) | (st_q.cr & (st_q.vr ^ st_q.hr));
        bw_bit  = (~st_q.vr & st_q.hr) | (st_q.cr & ~(st_q.vr ^ st_q.hr));

        case (op.byp)
            BY_RAM:   st_d.bp = rd_bit;
            BY_SOUTH: st_d.bp = byp_in;
            BY_ZERO:  st_d.bp = 1'b0;
            default:  st_d.bp = st_q.bp;
        endcase

        case (op.vert)
            V_RAM:   st_d.vr = rd_bit;
            V_NORTH: st_d.vr = n_in;
            V_SOUTH: st_d.vr = s_in;
            V_HORZ:  st_d.vr = st_q.hr;
            V_CARRY: st_d.vr = st_q.cr;
            V_ZERO:  st_d.vr = 1'b0;
            default: st_d.vr = st_q.vr;
        endcase

        case (op.horz)
            H_RAM:   st_d.hr = rd_bit;
            H_EAST:  st_d.hr = e_in;
            H_WEST:  st_d.hr = w_in;
            H_VERT:  st_d.hr = st_q.vr;
            H_CARRY: st_d.hr = st_q.cr;
            H_ZERO:  st_d.hr = 1'b0;
            default: st_d.hr = st_q.hr;
        endcase

        case (op.carry)
            C_RAM:   st_d.cr = rd_bit;
            C_VERT:  st_d.cr = st_q.vr;
            C_HORZ:  st_d.cr = st_q.hr;
            C_CY:    st_d.cr = cy_bit;
            C_BW:    st_d.cr = bw_bit;
            C_ZERO:  st_d.cr = 1'b0;
            C_ONE:   st_d.cr = 1'b1;
            default: st_d.cr = st_q.cr;
        endcase

        if (wr_en) begin
            case (op.wsrc)
                W_BYP:   st_d.mem[addr] = st_q.bp;
                W_CARRY: st_d.mem[addr] = st_q.cr;
                W_SUM:   st_d.mem[addr] = sum_bit;
                default: st_d.mem[addr] = rd_bit;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vr_o  = st_q.vr;
    assign hr_o  = st_q.hr;
    assign byp_o = st_q.bp;

endmodule

// File: rtl/simd_links.sv
module simd_links #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                 chain,
    input  logic [ROWS*COLS-1:0] vr_all,
    input  logic [ROWS*COLS-1:0] hr_all,
    output logic [ROWS*COLS-1:0] n_all,
    output logic [ROWS*COLS-1:0] s_all,
    output logic [ROWS*COLS-1:0] e_all,
    output logic [ROWS*COLS-1:0] w_all
);

    localparam int LAST_C = COLS - 1;
    localparam int LAST_R = ROWS - 1;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            localparam int UP  = ((r + ROWS - 1) % ROWS) * COLS + c;
            localparam int DN  = ((r + 1) % ROWS) * COLS + c;

            assign n_all[IDX] = vr_all[UP];
            assign s_all[IDX] = vr_all[DN];

            if (c > 0) begin : g_w_in
                assign w_all[IDX] = hr_all[IDX - 1];
            end else if (r < LAST_R) begin : g_w_seam
                assign w_all[IDX] = chain ? hr_all[(r + 1) * COLS + LAST_C]
                                          : hr_all[r * COLS + LAST_C];
            end else begin : g_w_end
                assign w_all[IDX] = chain ? 1'b0 : hr_all[r * COLS + LAST_C];
            end

            if (c < LAST_C) begin : g_e_in
                assign e_all[IDX] = hr_all[IDX + 1];
            end else if (r > 0) begin : g_e_seam
                assign e_all[IDX] = chain ? hr_all[(r - 1) * COLS]
                                          : hr_all[r * COLS];
            end else begin : g_e_end
                assign e_all[IDX] = chain ? 1'b0 : hr_all[r * COLS];
            end
        end
    end

endmodule

// File: rtl/simd_cell_array.sv
module simd_cell_array
    import simd_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                chain_mode,
    input  logic [COLS-1:0]     south_in,
    output logic [COLS-1:0]     north_out
);

    localparam int CELLS = ROWS * COLS;

    typedef struct packed {
        logic chain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic mode_q;
    instr_t op;

    logic [CELLS-1:0] vr_all, hr_all, bp_all;
    logic [CELLS-1:0] n_all, s_all, e_all, w_all, bin_all;

    assign op     = instr_t'(instr);
    assign mode_q = ctl_q.chain;

    always_comb begin
        ctl_d = ctl_q;
        if (instr == '0) ctl_d.chain = chain_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    simd_links #(.ROWS(ROWS), .COLS(COLS)) links_i (
        .chain  (ctl_q.chain),
        .vr_all (vr_all),
        .hr_all (hr_all),
        .n_all  (n_all),
        .s_all  (s_all),
        .e_all  (e_all),
        .w_all  (w_all)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;

            if (r == ROWS - 1) begin : g_feed_bus
                assign bin_all[IDX] = south_in[c];
            end else begin : g_feed_cell
                assign bin_all[IDX] = bp_all[IDX + COLS];
            end

            simd_cell #(.ADDR_W(ADDR_W)) cell_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .op     (op),
                .addr   (addr),
                .wr_en  (wr_en),
                .n_in   (n_all[IDX]),
                .s_in   (s_all[IDX]),
                .e_in   (e_all[IDX]),
                .w_in   (w_all[IDX]),
                .byp_in (bin_all[IDX]),
                .vr_o   (vr_all[IDX]),
                .hr_o   (hr_all[IDX]),
                .byp_o  (bp_all[IDX])
            );
        end
    end

    assign north_out = bp_all[COLS-1:0];

endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk #(
    parameter int COLS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [12:0]     instr,
    input logic            chain_mode,
    input logic [COLS-1:0] north_out,
    input logic            mode_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (north_out == '0));

    // R2: clear code empties the top row on the next edge
    p_byp_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[1:0] == 2'b11) |=> (north_out == '0));

    // R2: hold code keeps the top row
    p_byp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[1:0] == 2'b00) |=> $stable(north_out));

    p_mode_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr != '0) |=> (mode_q == $past(mode_q)));

    p_mode_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == '0) |=> (mode_q == $past(chain_mode)));

endmodule

bind simd_cell_array simd_array_chk #(.COLS(COLS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .chain_mode (chain_mode),
    .north_out  (north_out),
    .mode_q     (mode_q)
);

// File: tb/simd_cell_array_tb.sv
module simd_cell_array_tb_top;

    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int ADDR_W = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam realtime HALF = 2.5ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [12:0]       instr = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              chain_mode = 1'b0;
    logic [COLS-1:0]   south_in = '0;
    logic [COLS-1:0]   north_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string phase = "R1";

    simd_cell_array #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .addr(addr), .wr_en(wr_en),
        .chain_mode(chain_mode), .south_in(south_in), .north_out(north_out)
    );

    always #(HALF) clk = ~clk;

    // behavioural reference state
    bit m_vr [ROWS][COLS];
    bit m_hr [ROWS][COLS];
    bit m_cr [ROWS][COLS];
    bit m_bp [ROWS][COLS];
    bit m_mem[ROWS][COLS][DEPTH];
    bit m_chain;

    function automatic bit h_side(int r, int c, int d);
        int p;
        if (!m_chain) return m_hr[r][(c + d + COLS) % COLS];
        p = (ROWS - 1 - r) * COLS + c + d;   // position along the serpentine
        if (p < 0 || p >= ROWS * COLS) return 1'b0;
        return m_hr[ROWS - 1 - p / COLS][p % COLS];
    endfunction

    function automatic logic [COLS-1:0] model_top();
        logic [COLS-1:0] w;
        for (int c = 0; c < COLS; c++) w[c] = m_bp[0][c];
        return w;
    endfunction

    task automatic model_step(logic [12:0] ins, int a, bit we, bit cm, logic [COLS-1:0] sin);
        bit nvr[ROWS][COLS]; bit nhr[ROWS][COLS];
        bit ncr[ROWS][COLS]; bit nbp[ROWS][COLS];
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int v, h, k, tot, diff;
                bit rd;
                v = m_vr[r][c]; h = m_hr[r][c]; k = m_cr[r][c];
                rd = m_mem[r][c][a];
                tot = v + h + k; diff = v - h - k;
                case (ins[1:0])
                    2'd1: nbp[r][c] = rd;
                    2'd2: nbp[r][c] = (r == ROWS - 1) ? sin[c] : m_bp[r+1][c];
                    2'd3: nbp[r][c] = 0;
                    default: nbp[r][c] = m_bp[r][c];
                endcase
                case (ins[4:2])
                    3'd1: nvr[r][c] = rd;
                    3'd2: nvr[r][c] = m_vr[(r + ROWS - 1) % ROWS][c];
                    3'd3: nvr[r][c] = m_vr[(r + 1) % ROWS][c];
                    3'd4: nvr[r][c] = h[0];
                    3'd5: nvr[r][c] = k[0];
                    3'd6: nvr[r][c] = 0;
                    default: nvr[r][c] = v[0];
                endcase
                case (ins[7:5])
                    3'd1: nhr[r][c] = rd;
                    3'd2: nhr[r][c] = h_side(r, c, 1);
                    3'd3: nhr[r][c] = h_side(r, c, -1);
                    3'd4: nhr[r][c] = v[0];
                    3'd5: nhr[r][c] = k[0];
                    3'd6: nhr[r][c] = 0;
                    default: nhr[r][c] = h[0];
                endcase
                case (ins[10:8])
                    3'd1: ncr[r][c] = rd;
                    3'd2: ncr[r][c] = v[0];
                    3'd3: ncr[r][c] = h[0];
                    3'd4: ncr[r][c] = (tot >= 2);
                    3'd5: ncr[r][c] = (diff < 0);
                    3'd6: ncr[r][c] = 0;
                    3'd7: ncr[r][c] = 1;
                    default: ncr[r][c] = k[0];
                endcase
                if (we) begin
                    case (ins[12:11])
                        2'd1: m_mem[r][c][a] = m_bp[r][c];
                        2'd2: m_mem[r][c][a] = k[0];
                        2'd3: m_mem[r][c][a] = tot[0];
                        default: ;
                    endcase
                end
            end
        end
        m_vr = nvr; m_hr = nhr; m_cr = ncr; m_bp = nbp;
        if (ins == 13'd0) m_chain = cm;
    endtask

    task automatic check(string tag, logic [COLS-1:0] got, logic [COLS-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: north_out got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // drive one cycle, advance the model, compare away from the edge
    task automatic step(logic [12:0] ins, int a = 0, bit we = 0, bit cm = 0,
                        logic [COLS-1:0] sin = '0);
        instr = ins; addr = ADDR_W'(a); wr_en = we; chain_mode = cm; south_in = sin;
        @(posedge clk);
        model_step(ins, a, we, cm, sin);
        #1;
        check(phase, north_out, model_top());
    endtask

    function automatic logic [12:0] mk(int ws, int cs, int hs, int vs, int bs);
        return {2'(ws), 3'(cs), 3'(hs), 3'(vs), 2'(bs)};
    endfunction

    // read RAM bit plane a out through the bypass path, row 0 first
    task automatic dump(int a, logic [COLS-1:0] exp[ROWS], string tag, bit cm = 0);
        step(mk(0, 0, 0, 0, 1), a, 0, cm);
        check(tag, north_out, exp[0]);
        for (int k = 1; k < ROWS; k++) begin
            step(mk(0, 0, 0, 0, 2), a, 0, cm);
            check(tag, north_out, exp[k]);
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [COLS-1:0] pat[ROWS];
        logic [COLS-1:0] exp[ROWS];
        logic [COLS-1:0] zer[ROWS];
        logic [COLS-1:0] ones[ROWS];
        logic [COLS-1:0] mask;
        mask = '1;
        for (int k = 0; k < ROWS; k++) begin
            pat[k]  = COLS'(k * 7 + 9);
            zer[k]  = '0;
            ones[k] = '1;
        end
        m_chain = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                m_vr[r][c] = 0; m_hr[r][c] = 0; m_cr[r][c] = 0; m_bp[r][c] = 0;
                for (int a = 0; a < DEPTH; a++) m_mem[r][c][a] = 0;
            end

        repeat (3) @(posedge clk);
        #1;
        check("R1", north_out, '0);
        rst_n = 1'b1;
        dump(0, zer, "R1");
        dump(DEPTH - 1, zer, "R1");

        // R3: words travel south to north in ROWS cycles
        phase = "R3";
        for (int k = 0; k < ROWS; k++) step(mk(0, 0, 0, 0, 2), 0, 0, 0, pat[k]);
        check("R3", north_out, pat[0]);
        for (int k = 1; k < ROWS; k++) begin
            step(mk(0, 0, 0, 0, 0));
            check("R2 hold", north_out, pat[0]);
        end

        // R7: store bypass plane into RAM bit 5, clear, read back
        phase = "R7";
        step(mk(1, 0, 0, 0, 3), 5, 1);
        check("R2 clear", north_out, '0);
        dump(5, pat, "R7");
        step(mk(1, 0, 0, 0, 0), 5, 0);
        dump(5, pat, "R7 no write");

        // R8: torus rotation of horizontal registers by one column
        phase = "R8";
        step(mk(0, 0, 1, 0, 0), 5);
        step(mk(0, 0, 3, 0, 0));
        step(mk(0, 3, 0, 0, 0));
        step(mk(2, 0, 0, 0, 0), 6, 1);
        for (int k = 0; k < ROWS; k++) exp[k] = ((pat[k] << 1) | (pat[k] >> (COLS - 1))) & mask;
        dump(6, exp, "R8");

        // R9: chain mode, eastward step across the row seams
        phase = "R9";
        step(13'd0, 0, 0, 1);
        step(mk(0, 0, 1, 0, 0), 5, 0, 0);
        step(mk(0, 0, 3, 0, 0), 0, 0, 0);
        step(mk(0, 3, 0, 0, 0), 0, 0, 0);
        step(mk(2, 0, 0, 0, 0), 7, 1, 0);
        for (int k = 0; k < ROWS; k++)
            exp[k] = ((pat[k] << 1) & mask) |
                     COLS'((k < ROWS - 1) ? pat[k+1][COLS-1] : 1'b0);
        dump(7, exp, "R9/R10 chain kept");

        // R9: westward step across the seams
        step(mk(0, 0, 1, 0, 0), 5, 0, 0);
        step(mk(0, 0, 2, 0, 0), 0, 0, 0);
        step(mk(0, 3, 0, 0, 0), 0, 0, 0);
        step(mk(2, 0, 0, 0, 0), 8, 1, 0);
        for (int k = 0; k < ROWS; k++)
            exp[k] = (pat[k] >> 1) |
                     ((k > 0) ? (COLS'(pat[k-1][0]) << (COLS - 1)) : '0);
        dump(8, exp, "R9");

        // R10: zero instruction returns to torus
        phase = "R10";
        step(13'd0, 0, 0, 0);
        step(mk(0, 0, 1, 0, 0), 5, 0, 1);
        step(mk(0, 0, 3, 0, 0), 0, 0, 1);
        step(mk(0, 3, 0, 0, 0), 0, 0, 1);
        step(mk(2, 0, 0, 0, 0), 9, 1, 1);
        for (int k = 0; k < ROWS; k++) exp[k] = ((pat[k] << 1) | (pat[k] >> (COLS - 1))) & mask;
        dump(9, exp, "R10");

        // R6: vr=1 hr=0 cr=1 gives sum 0 and carry 1
        phase = "R6";
        step(mk(0, 7, 6, 0, 0));
        step(mk(0, 0, 0, 5, 0));
        step(mk(3, 4, 0, 0, 0), 10, 1);
        step(mk(2, 0, 0, 0, 0), 11, 1);
        dump(10, zer, "R6 sum");
        dump(11, ones, "R6 carry");

        // R4/R5/R6/R11: randomized broadcast stream with concurrent shifting
        phase = "R4/R5/R6/R11";
        for (int i = 0; i < 600; i++) begin
            logic [12:0] ins;
            ins = 13'($urandom);
            if ($urandom % 10 == 0) ins = '0;
            step(ins, int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2),
                 COLS'($urandom));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule